// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the control-memory address of the next microinstruction in a microprogrammed control unit. It holds a control address register and a single-entry subroutine return register, both 7 bits wide, which cover a 128-word control store. On every clock, one of four sources loads the control address register:
- the incremented address;
- the saved return address;
- the address field of the current microinstruction;
- an address formed from the opcode of the current machine instruction.

The current microinstruction supplies the sequencing fields. A 2-bit condition selector picks a test bit from a constant one and three processor status bits. A 2-bit branch operation tells the block how to use that test bit. The control store looks up the microinstruction at the address on `car`, and the datapath executes it. Both of those lie outside this block.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads `car` with 64, the first word of the fetch routine, and clears `sbr` to 0.
- R2: The test bit is 1 for `condSel`=00, `indBit` for 01, `signBit` for 10 and `zeroBit` for 11. The two status bits that are not selected have no effect on the next `car`.
- R3: With `brOp`=00 (jump) and test bit 1, the next `car` is `addrField`. With test bit 0, the next `car` is `car`+1.
- R4: With `brOp`=01 (call) and test bit 1, the next `car` is `addrField` and `sbr` takes `car`+1.
- R5: With `brOp`=01 and test bit 0, the next `car` is `car`+1 and `sbr` keeps its value.
- R6: With `brOp`=10 (return), the next `car` is `sbr` whatever the test bit.
- R7: With `brOp`=11 (map), the next `car` is {0, `opcode[3:0]`, 00}, so opcode k starts at address 4k, whatever the test bit.
- R8: The incremented address wraps from 127 to 0, both on the fall-through path and in the return address saved by a call.
- R9: `sbr` changes only on a call whose test bit is 1, or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| condSel | input | 2 | Test-bit selector of the current microinstruction |
| brOp | input | 2 | Branch operation: 00 jump, 01 call, 10 return, 11 map |
| addrField | input | 7 | Address field of the current microinstruction |
| indBit | input | 1 | Indirect bit of the machine instruction |
| signBit | input | 1 | Sign of the accumulator |
| zeroBit | input | 1 | Accumulator-is-zero flag |
| opcode | input | 4 | Opcode of the current machine instruction |
| car | output | 7 | Current control address |
| sbr | output | 7 | Saved subroutine return address |

## Verification
The bench drives the status bits that are not selected to the opposite value of the selected one. A test-bit multiplexer with swapped select codes therefore steers jumps to the wrong place.

It issues a call whose test bit is 0, which exposes a design that updates the return register without checking the test bit. It also issues returns and maps while the selected test bit is 0, so a design that gates those operations on the test bit falls through to `car`+1.

Maps use the opcodes 0, 11 and 15, which catches a map that is shifted or missing its top zero. A call at address 127 must save a return address of 0, and a fall-through at 127 must wrap to 0.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    BR_JMP  = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } brOp_e;

  // Address-source select; the code order matches the four-way multiplexer.
  typedef enum logic [1:0] {
    SRC_INC = 2'b00,
    SRC_SBR = 2'b01,
    SRC_AD  = 2'b10,
    SRC_MAP = 2'b11
  } srcSel_e;

  typedef struct packed {
    srcSel_e src;
    logic    sbrLoad;
  } seqCtl_t;

endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic [1:0] condSel,
  input  logic [1:0] brOp,
  input  logic       indBit,
  input  logic       signBit,
  input  logic       zeroBit,
  output seqCtl_t    ctl
);

  logic [3:0] statusVec;
  logic       testBit;

  // Condition multiplexer: slot 0 is tied high for unconditional use.
  assign statusVec = {zeroBit, signBit, indBit, 1'b1};
  assign testBit   = statusVec[condSel];

  always_comb begin
    ctl.src     = SRC_INC;
    ctl.sbrLoad = 1'b0;
    case (brOp_e'(brOp))
      BR_JMP: begin
        ctl.src = testBit ? SRC_AD : SRC_INC;
      end
      BR_CALL: begin
        ctl.src     = testBit ? SRC_AD : SRC_INC;
        ctl.sbrLoad = testBit;
      end
      BR_RET:  ctl.src = SRC_SBR;
      BR_MAP:  ctl.src = SRC_MAP;
      default: ctl.src = SRC_INC;
    endcase
  end

endmodule

// File: rtl/useq_dpath.sv
module useq_dpath
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] addrField,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] car,
  output logic [ADDR_W-1:0] sbr
);

  localparam int LOW_ZEROS = ADDR_W - 1 - OPC_W;

  logic [ADDR_W-1:0] carInc;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] nextCar;

  assign carInc = car + ADDR_W'(1);

  // Opcode mapping: a leading zero, the opcode, then zero padding.
  generate
    if (LOW_ZEROS > 0) begin : gen_pad
      assign mapAddr = {1'b0, opcode, {LOW_ZEROS{1'b0}}};
    end else begin : gen_nopad
      assign mapAddr = {1'b0, opcode};
    end
  endgenerate

  always_comb begin
    case (ctl.src)
      SRC_INC: nextCar = carInc;
      SRC_SBR: nextCar = sbr;
      SRC_AD:  nextCar = addrField;
      SRC_MAP: nextCar = mapAddr;
      default: nextCar = carInc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= ADDR_W'(RESET_ADDR);
      sbr <= '0;
    end else begin
      car <= nextCar;
      if (ctl.sbrLoad) sbr <= carInc;
    end
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        condSel,
  input  logic [1:0]        brOp,
  input  logic [ADDR_W-1:0] addrField,
  input  logic              indBit,
  input  logic              signBit,
  input  logic              zeroBit,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] car,
  output logic [ADDR_W-1:0] sbr
);

  seqCtl_t ctl;

  useq_ctrl u_ctrl (
    .condSel (condSel),
    .brOp    (brOp),
    .indBit  (indBit),
    .signBit (signBit),
    .zeroBit (zeroBit),
    .ctl     (ctl)
  );

  useq_dpath #(
    .ADDR_W     (ADDR_W),
    .OPC_W      (OPC_W),
    .RESET_ADDR (RESET_ADDR)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .addrField (addrField),
    .opcode    (opcode),
    .car       (car),
    .sbr       (sbr)
  );

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int RESET_ADDR = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        condSel,
  input logic [1:0]        brOp,
  input logic [ADDR_W-1:0] addrField,
  input logic              indBit,
  input logic              signBit,
  input logic              zeroBit,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] car,
  input logic [ADDR_W-1:0] sbr
);

  localparam int LOW_ZEROS = ADDR_W - 1 - OPC_W;

  // Independent model of the selected test bit (R2).
  logic tb;
  always_comb begin
    case (condSel)
      2'b00:   tb = 1'b1;
      2'b01:   tb = indBit;
      2'b10:   tb = signBit;
      default: tb = zeroBit;
    endcase
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (car == ADDR_W'(RESET_ADDR)) && (sbr == '0));

  assert_jump_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (brOp == 2'b00 && tb) |=> car == $past(addrField));

  assert_call_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (brOp == 2'b01 && tb) |=>
      (car == $past(addrField)) && (sbr == ADDR_W'($past(car) + 1'b1)));

  assert_fall_through_R5: assert property (@(posedge clk) disable iff (rst)
    (!brOp[1] && !tb) |=> car == ADDR_W'($past(car) + 1'b1));

  assert_return_R6: assert property (@(posedge clk) disable iff (rst)
    (brOp == 2'b10) |=> car == $past(sbr));

  assert_map_R7: assert property (@(posedge clk) disable iff (rst)
    (brOp == 2'b11) |=>
      car == ADDR_W'({1'b0, $past(opcode)} << LOW_ZEROS));

  assert_sbr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(brOp == 2'b01 && tb) |=> $stable(sbr));

endmodule

bind useq_top useq_chk #(
  .ADDR_W     (ADDR_W),
  .OPC_W      (OPC_W),
  .RESET_ADDR (RESET_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .condSel   (condSel),
  .brOp      (brOp),
  .addrField (addrField),
  .indBit    (indBit),
  .signBit   (signBit),
  .zeroBit   (zeroBit),
  .opcode    (opcode),
  .car       (car),
  .sbr       (sbr)
);

// File: tb/useq_top_test.sv
module useq_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] cs;
    logic [1:0] br;
    logic [6:0] ad;
    logic       ind;
    logic       sgn;
    logic       zro;
    logic [3:0] opc;
    logic [6:0] eCar;
    logic [6:0] eSbr;
  } vec_t;

  // Walked in order from the reset state car=64, sbr=0.
  localparam vec_t VECS [NVEC] = '{
    '{3, 0, 0,  65, 0, 0, 0,  0,  65,  0},  // R3 unconditional jump
    '{2, 1, 0,  10, 0, 1, 1,  0,  66,  0},  // R2 indirect=0, others high
    '{3, 1, 0,   3, 1, 0, 0,  0,   3,  0},  // R3 indirect taken
    '{4, 0, 1,  67, 0, 0, 0,  0,  67,  4},  // R4 call saves 4
    '{2, 2, 0,  20, 0, 1, 0,  0,  20,  4},  // R2 sign taken
    '{5, 3, 1,  90, 1, 1, 0,  0,  21,  4},  // R5 call not taken
    '{6, 3, 2,   0, 0, 0, 0,  0,   4,  4},  // R6 return with T=0
    '{7, 1, 3,   0, 0, 0, 0, 11,  44,  4},  // R7 map opcode 11
    '{7, 0, 3,   0, 0, 0, 0, 15,  60,  4},  // R7 map opcode 15
    '{7, 0, 3,   0, 0, 0, 0,  0,   0,  4},  // R7 map opcode 0
    '{4, 2, 1, 127, 0, 1, 0,  0, 127,  1},  // R4 call to 127
    '{8, 2, 0,   5, 1, 0, 1,  0,   0,  1},  // R8 fall-through wraps
    '{4, 1, 1, 100, 1, 0, 0,  0, 100,  1},  // R4 indirect call
    '{6, 0, 2,   0, 0, 0, 0,  0,   1,  1},  // R6 return
    '{2, 3, 0,  50, 0, 0, 1,  0,  50,  1},  // R2 zero taken
    '{4, 3, 1, 127, 0, 0, 1,  0, 127, 51},  // R4 call at 50
    '{8, 0, 1,  10, 0, 0, 0,  0,  10,  0},  // R8 saved return wraps
    '{6, 0, 2,   0, 0, 0, 0,  0,   0,  0}   // R6 return to 0
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] condSel;
  logic [1:0] brOp;
  logic [6:0] addrField;
  logic       indBit;
  logic       signBit;
  logic       zeroBit;
  logic [3:0] opcode;
  logic [6:0] car;
  logic [6:0] sbr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  useq_top uut (
    .clk       (clk),
    .rst       (rst),
    .condSel   (condSel),
    .brOp      (brOp),
    .addrField (addrField),
    .indBit    (indBit),
    .signBit   (signBit),
    .zeroBit   (zeroBit),
    .opcode    (opcode),
    .car       (car),
    .sbr       (sbr)
  );

  task automatic checkOut(input string tag, input logic [6:0] eCar,
                          input logic [6:0] eSbr);
    checks++;
    if (car !== eCar || sbr !== eSbr) begin
      errors++;
      $display("FAIL %s: car=%0d sbr=%0d expected car=%0d sbr=%0d",
               tag, car, sbr, eCar, eSbr);
    end
  endtask

  task automatic drive(input logic [1:0] cs, input logic [1:0] br,
                       input logic [6:0] ad, input logic ind,
                       input logic sgn, input logic zro,
                       input logic [3:0] opc);
    condSel = cs;
    brOp = br;
    addrField = ad;
    indBit = ind;
    signBit = sgn;
    zeroBit = zro;
    opcode = opc;
  endtask

  initial begin
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkOut("R1 reset state", 7'd64, 7'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].cs, VECS[i].br, VECS[i].ad, VECS[i].ind,
            VECS[i].sgn, VECS[i].zro, VECS[i].opc);
      @(negedge clk);
      checkOut($sformatf("R%0d vector %0d", VECS[i].req, i),
               VECS[i].eCar, VECS[i].eSbr);
    end

    // R9: a taken call first, then a map that must leave sbr alone.
    drive(0, 1, 7'd30, 0, 0, 0, 0);
    @(negedge clk);
    checkOut("R4 call from 0", 7'd30, 7'd1);
    drive(2, 3, 7'd90, 0, 0, 0, 4'd5);
    @(negedge clk);
    checkOut("R9 sbr held over map", 7'd20, 7'd1);

    // R1: reset overrides a taken call partway through a run.
    rst = 1'b1;
    drive(0, 1, 7'd99, 1, 1, 1, 4'd3);
    @(negedge clk);
    checkOut("R1 reset over call", 7'd64, 7'd0);
    rst = 1'b0;
    drive(0, 0, 7'd0, 0, 0, 0, 0);
    @(negedge clk);
    checkOut("R3 jump after reset", 7'd0, 7'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule